// File: doc/BRIEF.md
# Cartridge Disk Controller Host Register Front End

This block is the byte-wide register face of a cartridge disk controller. The host reaches it through five strobes: unit select, data write, data read, status read and command write. It decodes command bytes and keeps the controller status byte. It also owns the head/sector register and the one-byte data buffer that the transfer engine uses. When the engine finishes a transfer it reports back through a done strobe and a set of error flags.

The data ports change meaning with the controller state. While the controller is idle, a data write loads the head/sector register and a data read returns the sector now passing under the heads, from a free-running rotation counter. While a transfer is in progress, both ports work on the data buffer and mark the controller busy. A write command leaves the status byte entirely zero. Every other accepted command leaves only the busy bit set. On completion the block raises an interrupt pulse that cannot be masked. If any error flag came back, it also raises a channel-stop pulse.

Top module: `dskc_host_if`

## Requirements
- R1: After reset the host status reads 0x0A (busy bit 3 plus idle bit 1). The read data, head/sector register, data buffer, selected unit, platter and all pulse outputs are zero.
- R2: Status bit positions are: overrun 7, address compare fail 6, defective track 5, cylinder overflow 4, busy 3, examine 2, idle 1, transfer error 0. Examine reads as 1 exactly when any of bits 7..4 is set. A status-read strobe copies this host view into the read data on the next cycle.
- R3: A command byte with bit 3 set clears the controller to the R1 state, whatever its state. It also pulses the drive-reset output for one cycle. The rotation counter is not affected.
- R4: A command whose bit 3 is clear is ignored unless the controller is idle and the busy input of the selected drive is low.
- R5: An accepted command with code 2 (write) sets the status to 0x00. Any other accepted code sets it to 0x08.
- R6: Only accepted codes 1 (read), 2 (write) and 3 (read-check) give a one-cycle start pulse. The pulse comes with the latched code, the selected unit and the platter bit. Other codes are latched but start nothing.
- R7: A data read while idle returns the current sector number (0 to 23). Otherwise it returns the data buffer and sets busy.
- R8: A data write while idle loads the low 6 bits into the head/sector register and leaves the buffer alone. Otherwise it stores the full byte in the buffer and sets busy.
- R9: On a done strobe while not idle:
  - idle is set;
  - the error flags (mask 0xF1) are ORed into the status;
  - busy is cleared;
  - the interrupt pulses for one cycle.
  A done strobe while idle has no effect.
- R10: A completion that carries any error flag also pulses the channel-stop output together with the interrupt.
- R11: The sector counter advances once every ROT_DIV clock cycles after reset and wraps from 23 to 0.
- R12: Unit select and platter bit are latched only while idle. A select during a transfer is ignored.
- R13: When completion coincides with a data access, completion decides the status (busy ends up clear). The access still stores or returns the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_stb | input | 1 | Unit select strobe |
| sel_unit | input | UNIT_W | Unit number to select |
| sel_upper | input | 1 | Upper platter select |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | 8 | Data write byte |
| rd_stb | input | 1 | Data read strobe |
| st_rd_stb | input | 1 | Status read strobe |
| rd_data | output | 8 | Registered read data |
| cmd_stb | input | 1 | Command write strobe |
| cmd_data | input | 4 | Command field |
| drv_busy | input | NUM_DRV | Per-drive busy (seek in progress) |
| xfer_done | input | 1 | Transfer engine completion strobe |
| xfer_err | input | 8 | Error flags reported at completion |
| status | output | 8 | Host view of the status byte |
| xfer_start | output | 1 | Start-transfer pulse |
| xfer_cmd | output | 4 | Latched command code |
| xfer_unit | output | UNIT_W | Selected unit |
| xfer_upper | output | 1 | Latched platter bit |
| xfer_hdsc | output | 6 | Head/sector register |
| xfer_buf | output | 8 | Data buffer |
| irq | output | 1 | Completion interrupt pulse |
| chan_stop | output | 1 | Channel stop pulse on error |
| drv_reset | output | 1 | Drive reset pulse |

## Verification
Two same-cycle collisions are provoked. The first is a completion strobe in the very cycle of a buffered data write during a transfer. The second is a completion in the same cycle as a buffered data read. In both cases the status must show idle with busy clear, which is completion winning over the access's busy-set. The buffer must still take the written byte, or the read must still return the buffer contents rather than a sector number. A further done strobe sent while already idle must leave the status unchanged and give no interrupt.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    typedef struct packed {
        logic ovr;
        logic acf;
        logic dfct;
        logic cyo;
        logic bsy;
        logic exm;
        logic idl;
        logic dte;
    } stat_t;

    localparam logic [7:0] ERR_BITS   = 8'hF1;
    localparam logic [7:0] EXAM_SRC   = 8'hF0;
    localparam logic [7:0] BSY_BIT    = 8'h08;
    localparam logic [7:0] IDL_BIT    = 8'h02;
    localparam logic [7:0] RESET_STAT = 8'h0A;

    localparam logic [3:0] OP_READ  = 4'd1;
    localparam logic [3:0] OP_WRITE = 4'd2;
    localparam logic [3:0] OP_RCHK  = 4'd3;
    localparam int         CLR_POS  = 3;
    localparam int         HS_W     = 6;

    function automatic logic starts_xfer(input logic [3:0] code);
        return (code == OP_READ) || (code == OP_WRITE) || (code == OP_RCHK);
    endfunction

    function automatic logic [7:0] host_view(input stat_t s);
        logic [7:0] r;
        r    = s;
        r[2] = |(r & EXAM_SRC);
        return r;
    endfunction

endpackage

// File: rtl/dskc_rot_pos.sv
module dskc_rot_pos #(
    parameter int SECTORS = 24,
    parameter int ROT_DIV = 8,
    localparam int SEC_W = $clog2(SECTORS),
    localparam int PRE_W = (ROT_DIV > 1) ? $clog2(ROT_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [SEC_W-1:0] sector
);
    logic [PRE_W-1:0] pre;
    logic             tick;

    generate
        if (ROT_DIV > 1) begin : g_div
            assign tick = (pre == PRE_W'(ROT_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pre    <= '0;
            sector <= '0;
        end else if (tick) begin
            pre    <= '0;
            sector <= (sector == SEC_W'(SECTORS - 1)) ? '0 : sector + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/dskc_status.sv
module dskc_status
    import dskc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       accept,
    input  logic       acc_write,
    input  logic       done,
    input  logic [7:0] err_in,
    input  logic       touch,
    output stat_t      st
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= stat_t'(RESET_STAT);
        end else if (accept) begin
            st <= acc_write ? stat_t'(8'h00) : stat_t'(BSY_BIT);
        end else if (done) begin
            st <= stat_t'(((st | (err_in & ERR_BITS)) | IDL_BIT) & ~BSY_BIT);
        end else if (touch) begin
            st.bsy <= 1'b1;
        end
    end
endmodule

// File: rtl/dskc_regs.sv
module dskc_regs
    import dskc_pkg::*;
#(
    parameter int UNIT_W = 2,
    parameter int SEC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              idle,
    input  logic              sel_stb,
    input  logic [UNIT_W-1:0] sel_unit,
    input  logic              sel_upper,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    input  logic              st_rd_stb,
    input  logic [7:0]        host_stat,
    input  logic [SEC_W-1:0]  sector,
    input  logic              accept,
    input  logic [3:0]        cmd_code,
    output logic [HS_W-1:0]   hdsc,
    output logic [7:0]        dbuf,
    output logic [3:0]        cmd_q,
    output logic [UNIT_W-1:0] unit_q,
    output logic              plat_q,
    output logic [7:0]        rd_q
);
    logic upper_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hdsc    <= '0;
            dbuf    <= '0;
            cmd_q   <= '0;
            unit_q  <= '0;
            upper_q <= 1'b0;
            plat_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (sel_stb && idle) begin
                unit_q  <= sel_unit;
                upper_q <= sel_upper;
            end
            if (wr_stb) begin
                if (idle) hdsc <= wr_data[HS_W-1:0];
                else      dbuf <= wr_data;
            end
            if (st_rd_stb)    rd_q <= host_stat;
            else if (rd_stb)  rd_q <= idle ? 8'(sector) : dbuf;
            if (accept) begin
                cmd_q  <= cmd_code;
                plat_q <= upper_q;
            end
        end
    end
endmodule

// File: rtl/dskc_host_if.sv
module dskc_host_if
    import dskc_pkg::*;
#(
    parameter int NUM_DRV = 4,
    parameter int SECTORS = 24,
    parameter int ROT_DIV = 8,
    localparam int UNIT_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
    localparam int SEC_W  = $clog2(SECTORS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_stb,
    input  logic [UNIT_W-1:0]  sel_unit,
    input  logic               sel_upper,
    input  logic               wr_stb,
    input  logic [7:0]         wr_data,
    input  logic               rd_stb,
    input  logic               st_rd_stb,
    output logic [7:0]         rd_data,
    input  logic               cmd_stb,
    input  logic [3:0]         cmd_data,
    input  logic [NUM_DRV-1:0] drv_busy,
    input  logic               xfer_done,
    input  logic [7:0]         xfer_err,
    output logic [7:0]         status,
    output logic               xfer_start,
    output logic [3:0]         xfer_cmd,
    output logic [UNIT_W-1:0]  xfer_unit,
    output logic               xfer_upper,
    output logic [HS_W-1:0]    xfer_hdsc,
    output logic [7:0]         xfer_buf,
    output logic               irq,
    output logic               chan_stop,
    output logic               drv_reset
);
    stat_t            st;
    logic [SEC_W-1:0] sector;
    logic             idle;
    logic             clr;
    logic             accept;
    logic             done_q;
    logic             touch;
    logic             unit_busy;

    assign idle      = st.idl;
    assign clr       = cmd_stb && cmd_data[CLR_POS];
    assign unit_busy = drv_busy[xfer_unit];
    assign accept    = cmd_stb && !cmd_data[CLR_POS] && idle && !unit_busy;
    assign done_q    = xfer_done && !idle;
    assign touch     = (wr_stb || rd_stb) && !idle;
    assign status    = host_view(st);

    dskc_rot_pos #(.SECTORS(SECTORS), .ROT_DIV(ROT_DIV)) u_rot (
        .clk(clk), .rst(rst), .sector(sector)
    );

    dskc_status u_stat (
        .clk(clk), .rst(rst), .clr(clr), .accept(accept),
        .acc_write(cmd_data == OP_WRITE), .done(done_q),
        .err_in(xfer_err), .touch(touch), .st(st)
    );

    dskc_regs #(.UNIT_W(UNIT_W), .SEC_W(SEC_W)) u_regs (
        .clk(clk), .rst(rst), .clr(clr), .idle(idle),
        .sel_stb(sel_stb), .sel_unit(sel_unit), .sel_upper(sel_upper),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .st_rd_stb(st_rd_stb), .host_stat(status), .sector(sector),
        .accept(accept), .cmd_code(cmd_data),
        .hdsc(xfer_hdsc), .dbuf(xfer_buf), .cmd_q(xfer_cmd),
        .unit_q(xfer_unit), .plat_q(xfer_upper), .rd_q(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_start <= 1'b0;
            irq        <= 1'b0;
            chan_stop  <= 1'b0;
            drv_reset  <= 1'b0;
        end else begin
            xfer_start <= accept && starts_xfer(cmd_data);
            irq        <= done_q;
            chan_stop  <= done_q && |(xfer_err & ERR_BITS);
            drv_reset  <= clr;
        end
    end
endmodule

// File: rtl/dskc_host_if_chk.sv
module dskc_host_if_chk #(
    parameter int SECTORS = 24,
    parameter int SEC_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       status,
    input logic             irq,
    input logic             chan_stop,
    input logic             xfer_start,
    input logic [3:0]       xfer_cmd,
    input logic             cmd_stb,
    input logic             drv_reset,
    input logic [SEC_W-1:0] sector
);
    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> status[1]);
    assert_irq_from_active_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> !$past(status[1]));
    assert_start_not_idle_R5: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> !status[1]);
    assert_start_code_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> ($past(cmd_stb) && xfer_cmd >= 4'd1 && xfer_cmd <= 4'd3));
    assert_stop_with_irq_R10: assert property (@(posedge clk) disable iff (rst)
        chan_stop |-> irq);
    assert_sector_range_R11: assert property (@(posedge clk) disable iff (rst)
        32'(sector) < SECTORS);
    assert_clear_state_R3: assert property (@(posedge clk) disable iff (rst)
        drv_reset |-> status == 8'h0A);
endmodule

bind dskc_host_if dskc_host_if_chk #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst(rst), .status(status), .irq(irq), .chan_stop(chan_stop),
    .xfer_start(xfer_start), .xfer_cmd(xfer_cmd), .cmd_stb(cmd_stb),
    .drv_reset(drv_reset), .sector(sector)
);

// File: tb/test_dskc_host_if.sv
`timescale 1ns/1ps
module test_dskc_host_if;
    localparam int DIV = 8;
    localparam int NSEC = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_stb = 0, sel_upper = 0, wr_stb = 0, rd_stb = 0, st_rd_stb = 0;
    logic cmd_stb = 0, xfer_done = 0;
    logic [1:0] sel_unit = 0;
    logic [7:0] wr_data = 0, xfer_err = 0;
    logic [3:0] cmd_data = 0;
    logic [3:0] drv_busy = 0;
    logic [7:0] rd_data, status, xfer_buf;
    logic [3:0] xfer_cmd;
    logic [1:0] xfer_unit;
    logic [5:0] xfer_hdsc;
    logic xfer_start, xfer_upper, irq, chan_stop, drv_reset;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    dskc_host_if i_dskc_host_if (
        .clk(clk), .rst(rst), .sel_stb(sel_stb), .sel_unit(sel_unit),
        .sel_upper(sel_upper), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .st_rd_stb(st_rd_stb), .rd_data(rd_data),
        .cmd_stb(cmd_stb), .cmd_data(cmd_data), .drv_busy(drv_busy),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .status(status),
        .xfer_start(xfer_start), .xfer_cmd(xfer_cmd), .xfer_unit(xfer_unit),
        .xfer_upper(xfer_upper), .xfer_hdsc(xfer_hdsc), .xfer_buf(xfer_buf),
        .irq(irq), .chan_stop(chan_stop), .drv_reset(drv_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        sel_stb = 0; wr_stb = 0; rd_stb = 0; st_rd_stb = 0; cmd_stb = 0; xfer_done = 0;
    endtask

    // drive strobes set by caller at a negedge, then advance to next negedge
    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_cmd(input logic [3:0] c);
        cmd_stb = 1; cmd_data = c; step();
    endtask

    task automatic do_done(input logic [7:0] e);
        xfer_done = 1; xfer_err = e; step();
    endtask

    // op: 0 command, 1 data write, 2 completion, 3 status read
    // fields: op[18:17] arg[16:9] expected status[8:1] expected start[0]
    localparam logic [18:0] VEC [12] = '{
        {2'd1, 8'h25, 8'h0A, 1'b0},
        {2'd0, 8'h01, 8'h08, 1'b1},
        {2'd2, 8'h00, 8'h02, 1'b0},
        {2'd0, 8'h02, 8'h00, 1'b1},
        {2'd1, 8'h5A, 8'h08, 1'b0},
        {2'd2, 8'h40, 8'h46, 1'b0},
        {2'd3, 8'h00, 8'h46, 1'b0},
        {2'd0, 8'h05, 8'h08, 1'b0},
        {2'd2, 8'h01, 8'h03, 1'b0},
        {2'd0, 8'h03, 8'h08, 1'b1},
        {2'd2, 8'h81, 8'h87, 1'b0},
        {2'd0, 8'h08, 8'h0A, 1'b0}
    };

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'h0A);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 hdsc", xfer_hdsc, 0);
        chk("R1 buf", xfer_buf, 0);
        chk("R1 irq", irq, 0);

        // table walk: R2 R3 R5 R6 R8 R9 R10
        for (int i = 0; i < 12; i++) begin
            logic [1:0] op;
            logic [7:0] arg;
            op  = VEC[i][18:17];
            arg = VEC[i][16:9];
            case (op)
                2'd0: begin cmd_stb = 1; cmd_data = arg[3:0]; end
                2'd1: begin wr_stb = 1; wr_data = arg; end
                2'd2: begin xfer_done = 1; xfer_err = arg; end
                default: st_rd_stb = 1;
            endcase
            step();
            chk($sformatf("R5/R9 vec%0d status", i), status, VEC[i][8:1]);
            chk($sformatf("R6 vec%0d start", i), xfer_start, VEC[i][0]);
            if (VEC[i][0]) chk("R6 code", xfer_cmd, arg[3:0]);
            if (op == 2'd2) begin
                chk("R9 irq", irq, 1);
                chk("R10 chan_stop", chan_stop, (arg & 8'hF1) != 0);
            end
            if (op == 2'd3) chk("R2 status read", rd_data, VEC[i][8:1]);
            if (op == 2'd0 && arg[3]) chk("R3 drv_reset", drv_reset, 1);
        end
        chk("R3 hdsc cleared", xfer_hdsc, 0);
        chk("R3 buf cleared", xfer_buf, 0);

        // R8 idle write loads only 6 bits, buffer untouched
        wr_stb = 1; wr_data = 8'hE5; step();
        chk("R8 hdsc", xfer_hdsc, 6'h25);
        chk("R8 buf unchanged", xfer_buf, 0);

        // R7 buffered read during transfer
        do_cmd(4'd1);
        wr_stb = 1; wr_data = 8'h3C; step();
        chk("R8 busy write", xfer_buf, 8'h3C);
        rd_stb = 1; step();
        chk("R7 busy read", rd_data, 8'h3C);
        chk("R7 busy set", status, 8'h08);

        // R13 completion together with data write
        wr_stb = 1; wr_data = 8'h77; xfer_done = 1; xfer_err = 0; step();
        chk("R13 status after write+done", status, 8'h02);
        chk("R13 buffer stored", xfer_buf, 8'h77);
        // R9 done while idle ignored
        do_done(8'h80);
        chk("R9 idle done no irq", irq, 0);
        chk("R9 idle done status", status, 8'h02);
        // R13 completion together with data read
        do_cmd(4'd1);
        rd_stb = 1; xfer_done = 1; xfer_err = 0; step();
        chk("R13 read returns buffer", rd_data, 8'h77);
        chk("R13 status after read+done", status, 8'h02);

        // R4 selected drive busy blocks command
        drv_busy = 4'b0001;
        do_cmd(4'd1);
        chk("R4 drive busy status", status, 8'h02);
        chk("R4 drive busy start", xfer_start, 0);
        drv_busy = 4'b0000;
        // R4 command while not idle ignored
        do_cmd(4'd5);
        chk("R6 code5 status", status, 8'h08);
        do_cmd(4'd1);
        chk("R4 not idle start", xfer_start, 0);
        chk("R4 not idle code", xfer_cmd, 4'd5);
        do_done(8'h00);

        // R12 select latching
        sel_stb = 1; sel_unit = 2'd2; sel_upper = 1; step();
        do_cmd(4'd1);
        chk("R12 unit", xfer_unit, 2);
        chk("R6 platter", xfer_upper, 1);
        sel_stb = 1; sel_unit = 2'd1; sel_upper = 0; step();
        do_done(8'h00);
        chk("R12 select ignored while busy", xfer_unit, 2);

        // R11 / R7 rotational position reads while idle
        for (int k = 0; k < 30; k++) begin
            int exp_sec;
            repeat (3) @(negedge clk);
            exp_sec = (cyc / DIV) % NSEC;
            rd_stb = 1; step();
            chk("R11 sector", rd_data, exp_sec);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule